// File: doc/BRIEF.md
# Hexadecimal Seven-Segment Decoder with Ripple Blanking

This block is purely combinational. It turns a 4-bit hexadecimal digit into the seven drive lines of one display digit. All sixteen codes get a visible symbol. Three active-low controls sit on top of the plain decode:

- a forced blank input, which darkens the digit;
- a lamp test input, which lights every segment so a display can be checked;
- a ripple blanking input, which suppresses a zero digit.

An active-low ripple blanking output tells the next, less significant decoder whether suppression should continue. This lets leading zeros be removed across a multi-digit display.

In a chain, the most significant decoder has its ripple input tied low. Each ripple output feeds the ripple input of the digit to its right. The least significant decoder has its ripple input tied high, so a value of zero still shows one `0`.

Internally, a control stage picks one of four display modes:

| Mode | Meaning |
|------|---------|
| `MODE_BLANK` | forced dark |
| `MODE_LAMP` | all segments lit |
| `MODE_SUPPRESS` | zero removed by ripple blanking |
| `MODE_SHOW` | normal decode |

A glyph stage gives the symbol pattern. A polarity stage shapes the outputs.

Top module: `hexseg_decoder`

## Requirements
- R1: With `blank_n_i`, `lamp_test_n_i` and `ripple_n_i` all high, each `digit_i` value 0..15 drives `seg_o` with that digit's pattern, and `ripple_n_o` is high.
  - `seg_o` bit 0 is segment a and bit 6 is segment g.
  - With the default polarity, 0 means lit.
  - Digits 10..15 show A, b, C, d, E, F.
  - The lit masks, bit 6 down to bit 0, are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71 (hex).
- R2: When `blank_n_i` is low, every segment is dark (`seg_o` = 7'h7F) and `ripple_n_o` is high, whatever the other inputs are.
- R3: When `blank_n_i` is high and `lamp_test_n_i` is low, every segment is lit (`seg_o` = 7'h00) and `ripple_n_o` is high, whatever `digit_i` and `ripple_n_i` are.
- R4: When `blank_n_i` and `lamp_test_n_i` are high, `ripple_n_i` is low and `digit_i` is 0, all segments are dark and `ripple_n_o` is low.
- R5: A zero digit with `ripple_n_i` high, and both other controls high, shows the 0 pattern and drives `ripple_n_o` high.
- R6: A nonzero digit is shown whatever the level of `ripple_n_i`, and `ripple_n_o` is high.
- R7: In a four-digit chain with the top ripple input low and the bottom one high:
  - zeros to the left of the first nonzero digit are dark;
  - zeros to its right are shown;
  - an all-zero value shows only the rightmost 0.
- R8: `ripple_n_o` is low only in the R4 condition, and all 128 input combinations match the priority blank > lamp test > ripple suppression > normal decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_i | input | 4 | Hexadecimal digit to show |
| blank_n_i | input | 1 | Forced blank, active low, highest priority |
| lamp_test_n_i | input | 1 | Lamp test, active low, lights all segments |
| ripple_n_i | input | 1 | Ripple blanking in, active low, suppresses a zero digit |
| seg_o | output | 7 | Segment lines, bit 0 = a .. bit 6 = g, active low by default |
| ripple_n_o | output | 1 | Ripple blanking out, active low, feeds the next digit's ripple input |

## Verification
The bench builds the decoder with its default active-low segment polarity, `SEG_ACTIVE_LOW = 1`. This puts the 0-means-lit output patterns and the all-dark value 7'h7F within reach of every check. With only seven input bits, an exhaustive sweep over all 128 combinations is compared against an independent priority model. A four-instance chain covers leading-zero suppression, including the all-zero and embedded-zero cases.

// File: rtl/hexseg_pkg.sv
package hexseg_pkg;

    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned SEG_W   = 7;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    typedef enum logic [1:0] {
        MODE_BLANK    = 2'd0,
        MODE_LAMP     = 2'd1,
        MODE_SUPPRESS = 2'd2,
        MODE_SHOW     = 2'd3
    } disp_mode_e;

    localparam seg_t SEG_NONE = '0;
    localparam seg_t SEG_ALL  = '1;

endpackage

// File: rtl/hexseg_glyph.sv
module hexseg_glyph
    import hexseg_pkg::*;
(
    input  digit_t digit_i,
    output seg_t   lit_o
);
    // Lit mask, bit 0 = a .. bit 6 = g, 1 = segment on
    always_comb begin
        unique case (digit_i)
            4'h0: lit_o = 7'h3F;
            4'h1: lit_o = 7'h06;
            4'h2: lit_o = 7'h5B;
            4'h3: lit_o = 7'h4F;
            4'h4: lit_o = 7'h66;
            4'h5: lit_o = 7'h6D;
            4'h6: lit_o = 7'h7D;
            4'h7: lit_o = 7'h07;
            4'h8: lit_o = 7'h7F;
            4'h9: lit_o = 7'h6F;
            4'hA: lit_o = 7'h77;
            4'hB: lit_o = 7'h7C;
            4'hC: lit_o = 7'h39;
            4'hD: lit_o = 7'h5E;
            4'hE: lit_o = 7'h79;
            default: lit_o = 7'h71;
        endcase
    end
endmodule

// File: rtl/hexseg_ctrl.sv
module hexseg_ctrl
    import hexseg_pkg::*;
(
    input  logic       blank_n_i,
    input  logic       lamp_n_i,
    input  logic       ripple_n_i,
    input  logic       is_zero_i,
    output disp_mode_e mode_o,
    output logic       ripple_n_o
);
    // Priority: blank, then lamp test, then zero suppression
    always_comb begin
        unique casez ({blank_n_i, lamp_n_i, ripple_n_i, is_zero_i})
            4'b0???: mode_o = MODE_BLANK;
            4'b10??: mode_o = MODE_LAMP;
            4'b1101: mode_o = MODE_SUPPRESS;
            default: mode_o = MODE_SHOW;
        endcase
    end

    always_comb begin
        ripple_n_o = (mode_o != MODE_SUPPRESS);
    end

    // R8
    always_comb begin
        if (!$isunknown({blank_n_i, lamp_n_i, ripple_n_i, is_zero_i})) begin
            ripple_only_zero_chk: assert (ripple_n_o || (is_zero_i && !ripple_n_i))
                else $error("ripple out low without a suppressed zero");
        end
    end
endmodule

// File: rtl/hexseg_decoder.sv
module hexseg_decoder
    import hexseg_pkg::*;
#(
    parameter bit SEG_ACTIVE_LOW = 1'b1
) (
    input  logic [3:0] digit_i,
    input  logic       blank_n_i,
    input  logic       lamp_test_n_i,
    input  logic       ripple_n_i,
    output logic [6:0] seg_o,
    output logic       ripple_n_o
);
    localparam seg_t DARK_OUT = SEG_ACTIVE_LOW ? SEG_ALL : SEG_NONE;
    localparam seg_t LIT_OUT  = SEG_ACTIVE_LOW ? SEG_NONE : SEG_ALL;

    seg_t       glyph_lit;
    seg_t       lit_mask;
    disp_mode_e mode;
    logic       is_zero;

    assign is_zero = (digit_i == '0);

    hexseg_glyph u_glyph (
        .digit_i (digit_i),
        .lit_o   (glyph_lit)
    );

    hexseg_ctrl u_ctrl (
        .blank_n_i  (blank_n_i),
        .lamp_n_i   (lamp_test_n_i),
        .ripple_n_i (ripple_n_i),
        .is_zero_i  (is_zero),
        .mode_o     (mode),
        .ripple_n_o (ripple_n_o)
    );

    always_comb begin
        unique case (mode)
            MODE_BLANK:    lit_mask = SEG_NONE;
            MODE_LAMP:     lit_mask = SEG_ALL;
            MODE_SUPPRESS: lit_mask = SEG_NONE;
            default:       lit_mask = glyph_lit;
        endcase
    end

    generate
        if (SEG_ACTIVE_LOW) begin : g_pol_low
            assign seg_o = ~lit_mask;
        end else begin : g_pol_high
            assign seg_o = lit_mask;
        end
    endgenerate

    always_comb begin
        if (!$isunknown({digit_i, blank_n_i, lamp_test_n_i, ripple_n_i, seg_o, ripple_n_o})) begin
            // R2
            blank_dark_chk: assert (blank_n_i || (seg_o == DARK_OUT && ripple_n_o))
                else $error("forced blank not dark");
            // R3
            lamp_lit_chk: assert (!blank_n_i || lamp_test_n_i || (seg_o == LIT_OUT && ripple_n_o))
                else $error("lamp test not fully lit");
            // R4
            suppress_dark_chk: assert (ripple_n_o || (seg_o == DARK_OUT && digit_i == 4'h0))
                else $error("suppressed digit not dark");
            // R6
            nonzero_pass_chk: assert (digit_i == 4'h0 || ripple_n_o)
                else $error("nonzero digit pulled ripple out low");
        end
    end
endmodule

// File: tb/hexseg_decoder_tb.sv
module hexseg_decoder_tb;
    localparam int CLK_PERIOD = 10;

    // active-high lit masks, bit0 = a
    localparam logic [6:0] GLYPH [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
    };

    // {digit[3:0], blank_n, lamp_n, ripple_n, exp_seg[6:0], exp_rbo}
    localparam int NVEC = 10;
    localparam logic [14:0] VEC [NVEC] = '{
        {4'h8, 1'b0, 1'b0, 1'b0, 7'h7F, 1'b1},  // R2 blank beats lamp
        {4'h0, 1'b0, 1'b1, 1'b0, 7'h7F, 1'b1},  // R2 blank, zero, ripple low
        {4'h0, 1'b1, 1'b0, 1'b0, 7'h00, 1'b1},  // R3 lamp beats suppression
        {4'h5, 1'b1, 1'b0, 1'b1, 7'h00, 1'b1},  // R3
        {4'h0, 1'b1, 1'b1, 1'b0, 7'h7F, 1'b0},  // R4
        {4'h0, 1'b1, 1'b1, 1'b1, 7'h40, 1'b1},  // R5
        {4'h1, 1'b1, 1'b1, 1'b0, 7'h79, 1'b1},  // R6
        {4'hF, 1'b1, 1'b1, 1'b0, 7'h0E, 1'b1},  // R6
        {4'hA, 1'b1, 1'b1, 1'b1, 7'h08, 1'b1},  // R1
        {4'hB, 1'b1, 1'b1, 1'b1, 7'h03, 1'b1}   // R1
    };

    logic       clk = 1'b0;
    logic [3:0] digit;
    logic       blank_n, lamp_n, ripple_n;
    logic [6:0] seg;
    logic       rbo;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hexseg_decoder u_dut (
        .digit_i       (digit),
        .blank_n_i     (blank_n),
        .lamp_test_n_i (lamp_n),
        .ripple_n_i    (ripple_n),
        .seg_o         (seg),
        .ripple_n_o    (rbo)
    );

    // four-digit chain, index 3 most significant
    logic [15:0] chain_val;
    logic [6:0]  chain_seg [4];
    logic [3:0]  chain_rbo;
    logic [4:0]  chain_rbi;
    assign chain_rbi[4] = 1'b0;

    for (genvar k = 0; k < 4; k++) begin : g_chain
        logic rbi_k;
        assign rbi_k = (k == 0) ? 1'b1 : chain_rbi[k+1];
        hexseg_decoder u_chain (
            .digit_i       (chain_val[4*k +: 4]),
            .blank_n_i     (1'b1),
            .lamp_test_n_i (1'b1),
            .ripple_n_i    (rbi_k),
            .seg_o         (chain_seg[k]),
            .ripple_n_o    (chain_rbo[k])
        );
        assign chain_rbi[k] = chain_rbo[k];
    end

    function automatic logic [7:0] model(input logic [3:0] d, input logic b, input logic l, input logic r);
        if (!b)                return {7'h7F, 1'b1};
        if (!l)                return {7'h00, 1'b1};
        if (!r && d == 4'h0)   return {7'h7F, 1'b0};
        return {~GLYPH[d], 1'b1};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: seg/rbo actual=%h/%b expected=%h/%b", req, act[7:1], act[0], exp[7:1], exp[0]);
        end
    endtask

    task automatic apply(input logic [3:0] d, input logic b, input logic l, input logic r);
        @(posedge clk);
        digit = d; blank_n = b; lamp_n = l; ripple_n = r;
        @(negedge clk);
    endtask

    task automatic check_chain(input logic [15:0] v);
        logic lead;
        @(posedge clk);
        chain_val = v;
        @(negedge clk);
        lead = 1'b1;
        for (int k = 3; k >= 0; k--) begin
            logic [3:0] d;
            d = v[4*k +: 4];
            if (d != 0) lead = 1'b0;
            if (lead && k != 0)
                check("R7", {chain_seg[k], 1'b0}, {7'h7F, 1'b0});
            else
                check("R7", {chain_seg[k], 1'b0}, {~GLYPH[d], 1'b0});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        digit = 4'h0; blank_n = 1'b1; lamp_n = 1'b1; ripple_n = 1'b1;
        chain_val = 16'h0000;
        @(negedge clk);
        // idle state: zero shown, ripple out high (R5)
        check("R5", {seg, rbo}, {7'h40, 1'b1});

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][14:11], VEC[i][10], VEC[i][9], VEC[i][8]);
            check("R2-R6 vector", {seg, rbo}, VEC[i][7:0]);
        end

        for (int d = 0; d < 16; d++) begin
            apply(4'(d), 1'b1, 1'b1, 1'b1);
            check("R1", {seg, rbo}, {~GLYPH[d], 1'b1});
        end

        for (int n = 0; n < 128; n++) begin
            logic [6:0] c;
            c = 7'(n);
            apply(c[6:3], c[2], c[1], c[0]);
            check("R8", {seg, rbo}, model(c[6:3], c[2], c[1], c[0]));
        end

        check_chain(16'h0000);
        check_chain(16'h0007);
        check_chain(16'h0105);
        check_chain(16'h00A0);
        check_chain(16'h1000);
        check_chain(16'hF00F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule